// File: doc/BRIEF.md
# Top-K Candidate Tracker

This block keeps the K highest-ranked (row, score) candidates that a similarity-search engine has produced since the last clear. Candidates arrive one at a time on a valid/ready input. The block holds a sorted list of K entries with the best entry at index 0, and it drives the whole list on two packed output vectors.

A controller pulses `clear` at the start of each query. It then streams the candidates in. The query is complete once every candidate has been handed over and `merge_pending` is low.

Insertion is one cycle wide. Every slot compares the held candidate against its own entry. Each slot then keeps its entry, takes the entry from the slot above, or takes the new candidate. Whatever falls off the bottom of the list is dropped.

Top module: `rank_keeper`

## Requirements
- R1: After an asynchronous active-low reset, every entry is empty (score 0, row all ones), `merge_pending` is low and `cand_ready` is high.
- R2: A candidate is accepted on a clock edge where `cand_valid` and `cand_ready` are both high. In the following cycle `merge_pending` is high and `cand_ready` is low. `merge_pending` lasts exactly one cycle, after which `cand_ready` returns high.
- R3: The list with the accepted candidate merged in appears on the outputs on the edge that ends the pending cycle. The list is always ordered best first.
- R4: Ranking works as follows. A higher score ranks above a lower score. Between equal scores, the smaller row index ranks above the larger one.
- R5: A candidate that ranks above the last entry is inserted at its ordered position. The entries below that position each move down one slot, and the previous last entry is discarded.
- R6: A candidate that does not rank above the last entry leaves the list unchanged. This includes a candidate that ties the last entry exactly, and also a candidate equal to the empty marker (score 0, row all ones).
- R7: A one-cycle `clear` empties the list on the next edge. While `clear` is high, `cand_ready` is low, so a candidate offered in the same cycle is not accepted and never reaches the list.
- R8: A `clear` that arrives during the pending cycle discards the candidate being merged. On the next edge, `merge_pending` goes low and the list is empty.
- R9: Entry i occupies bits [i*ROW_W +: ROW_W] of `list_rows` and bits [i*SCORE_W +: SCORE_W] of `list_scores`.
- R10: With K = 1, the single entry always holds the best candidate seen since the last clear, ranked as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | One-cycle pulse that empties the list for a new query |
| cand_valid | input | 1 | A candidate is offered |
| cand_ready | output | 1 | The tracker can take a candidate this cycle |
| cand_row | input | ROW_W | Row index of the offered candidate |
| cand_score | input | SCORE_W | Score of the offered candidate |
| list_rows | output | K*ROW_W | Row indices of the retained entries, entry 0 in the low bits |
| list_scores | output | K*SCORE_W | Scores of the retained entries, entry 0 in the low bits |
| merge_pending | output | 1 | An accepted candidate has not yet been merged |

## Verification
Two cases put a clear and a candidate in the same cycle.

In the first case, the bench raises `clear` and `cand_valid` together. It expects `cand_ready` to be low, and it expects an empty list with no pending flag afterwards.

In the second case, the bench raises `clear` exactly in the cycle after an acceptance, while the merge is still pending. It expects the clear to win: the held candidate must never appear in the list, and the pending flag must drop on the same edge.

// File: rtl/rank_keeper.sv
module rank_keeper #(
  parameter int K       = 4,
  parameter int ROW_W   = 8,
  parameter int SCORE_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 cand_valid,
  output logic                 cand_ready,
  input  logic [ROW_W-1:0]     cand_row,
  input  logic [SCORE_W-1:0]   cand_score,
  output logic [K*ROW_W-1:0]   list_rows,
  output logic [K*SCORE_W-1:0] list_scores,
  output logic                 merge_pending
);

  localparam logic [ROW_W-1:0]   EMPTY_ROW   = '1;
  localparam logic [SCORE_W-1:0] EMPTY_SCORE = '0;

  logic [ROW_W-1:0]   row_q   [K];
  logic [SCORE_W-1:0] score_q [K];
  logic [ROW_W-1:0]   row_d   [K];
  logic [SCORE_W-1:0] score_d [K];
  logic [ROW_W-1:0]   hold_row;
  logic [SCORE_W-1:0] hold_score;
  logic               pend_q;
  logic [K-1:0]       beats;

  assign cand_ready    = !pend_q && !clear;
  assign merge_pending = pend_q;
  wire take = cand_valid && cand_ready;

  always_comb begin
    logic             prev_beat;
    logic [ROW_W-1:0] prev_row;
    logic [SCORE_W-1:0] prev_score;
    prev_beat  = 1'b0;
    prev_row   = hold_row;
    prev_score = hold_score;
    for (int i = 0; i < K; i++) begin
      beats[i] = (hold_score > score_q[i]) ||
                 ((hold_score == score_q[i]) && (hold_row < row_q[i]));
      row_d[i]   = row_q[i];
      score_d[i] = score_q[i];
      if (beats[i]) begin
        row_d[i]   = prev_beat ? prev_row   : hold_row;
        score_d[i] = prev_beat ? prev_score : hold_score;
      end
      prev_beat  = beats[i];
      prev_row   = row_q[i];
      prev_score = score_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      hold_row   <= '0;
      hold_score <= '0;
      for (int i = 0; i < K; i++) begin
        row_q[i]   <= EMPTY_ROW;
        score_q[i] <= EMPTY_SCORE;
      end
    end else if (clear) begin
      pend_q <= 1'b0;
      for (int i = 0; i < K; i++) begin
        row_q[i]   <= EMPTY_ROW;
        score_q[i] <= EMPTY_SCORE;
      end
    end else begin
      pend_q <= take;
      if (take) begin
        hold_row   <= cand_row;
        hold_score <= cand_score;
      end
      if (pend_q) begin
        row_q   <= row_d;
        score_q <= score_d;
      end
    end
  end

  for (genvar g = 0; g < K; g++) begin : g_out
    assign list_rows[g*ROW_W +: ROW_W]       = row_q[g];
    assign list_scores[g*SCORE_W +: SCORE_W] = score_q[g];
  end

  logic order_ok;
  always_comb begin
    order_ok = 1'b1;
    for (int i = 1; i < K; i++)
      if (!((score_q[i-1] > score_q[i]) ||
            ((score_q[i-1] == score_q[i]) && (row_q[i-1] <= row_q[i]))))
        order_ok = 1'b0;
  end

  AST_ACCEPT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready) |=> merge_pending);                       // R2
  AST_PENDING_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    merge_pending |=> !merge_pending);                                   // R2
  AST_LIST_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
    order_ok);                                                           // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (list_scores == '0 && list_rows == '1));                   // R7
  AST_CLEAR_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !merge_pending);                                           // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!merge_pending && !clear) |=> ($stable(list_rows) && $stable(list_scores))); // R6

endmodule

// File: tb/rank_keeper_test.sv
module rank_keeper_test;
  localparam int K = 4;
  localparam int RW = 8;
  localparam int SW = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic clear = 0;
  logic cand_valid = 0;
  logic [RW-1:0] cand_row = 0;
  logic [SW-1:0] cand_score = 0;
  logic cand_ready, merge_pending;
  logic [K*RW-1:0] list_rows;
  logic [K*SW-1:0] list_scores;

  logic v1 = 0;
  logic [RW-1:0] r1 = 0;
  logic [SW-1:0] s1 = 0;
  logic rdy1, pend1;
  logic [RW-1:0] rows1;
  logic [SW-1:0] scores1;

  int checks = 0;
  int fails = 0;
  int mrow [K];
  int mscore [K];

  always #10 clk = ~clk;

  rank_keeper #(.K(K), .ROW_W(RW), .SCORE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cand_valid(cand_valid),
    .cand_ready(cand_ready), .cand_row(cand_row), .cand_score(cand_score),
    .list_rows(list_rows), .list_scores(list_scores), .merge_pending(merge_pending));

  rank_keeper #(.K(1), .ROW_W(RW), .SCORE_W(SW)) uut_k1 (
    .clk(clk), .rst_n(rst_n), .clear(1'b0), .cand_valid(v1),
    .cand_ready(rdy1), .cand_row(r1), .cand_score(s1),
    .list_rows(rows1), .list_scores(scores1), .merge_pending(pend1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_empty();
    for (int i = 0; i < K; i++) begin mrow[i] = 255; mscore[i] = 0; end
  endtask

  function automatic bit above(int r, int s, int rr, int ss);
    return (s > ss) || (s == ss && r < rr);
  endfunction

  task automatic model_insert(input int r, input int s);
    for (int p = 0; p < K; p++) begin
      if (above(r, s, mrow[p], mscore[p])) begin
        for (int j = K - 1; j > p; j--) begin
          mrow[j] = mrow[j-1]; mscore[j] = mscore[j-1];
        end
        mrow[p] = r; mscore[p] = s;
        return;
      end
    end
  endtask

  // R9: entries are read out by their packed slice positions
  task automatic check_list(input string req);
    for (int i = 0; i < K; i++) begin
      check(list_rows[i*RW +: RW] == RW'(mrow[i]), {req, " R9 row"},
            int'(list_rows[i*RW +: RW]), mrow[i]);
      check(list_scores[i*SW +: SW] == SW'(mscore[i]), {req, " R9 score"},
            int'(list_scores[i*SW +: SW]), mscore[i]);
    end
  endtask

  task automatic offer(input int r, input int s, input string req);
    @(negedge clk);
    cand_valid = 1; cand_row = RW'(r); cand_score = SW'(s);
    #1 check(cand_ready == 1, {req, " R2 ready before accept"}, cand_ready, 1);
    @(negedge clk);
    cand_valid = 0;
    check(merge_pending == 1, {req, " R2 pending after accept"}, merge_pending, 1);
    check(cand_ready == 0, {req, " R2 ready low while pending"}, cand_ready, 0);
    @(negedge clk);
    check(merge_pending == 0, {req, " R2 pending one cycle"}, merge_pending, 0);
    model_insert(r, s);
    check_list(req);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    model_empty();
  endtask

  task automatic t_reset();
    model_empty();
    check(cand_ready == 1, "R1 ready", cand_ready, 1);
    check(merge_pending == 0, "R1 pending", merge_pending, 0);
    check_list("R1 empty");
  endtask

  task automatic t_order();
    do_clear();
    offer(5, 10, "R3");
    offer(3, 20, "R3");
    offer(9, 10, "R4 tie larger row");
    offer(2, 10, "R4 tie smaller row");
  endtask

  task automatic t_evict();
    offer(1, 15, "R5 middle insert");
    offer(0, 30, "R5 top insert");
  endtask

  task automatic t_reject();
    offer(7, 10, "R6 tie worse row");
    offer(2, 10, "R6 exact tie");
    offer(4, 3, "R6 low score");
    offer(1, 10, "R5 tie better row");
  endtask

  task automatic t_clear_with_valid();
    @(negedge clk);
    clear = 1; cand_valid = 1; cand_row = 8'd6; cand_score = 6'd60;
    #1 check(cand_ready == 0, "R7 ready low during clear", cand_ready, 0);
    @(negedge clk);
    clear = 0; cand_valid = 0;
    model_empty();
    check(merge_pending == 0, "R7 nothing accepted", merge_pending, 0);
    @(negedge clk);
    check_list("R7 empty after clear");
  endtask

  task automatic t_clear_pending();
    offer(12, 40, "R8 setup");
    @(negedge clk);
    cand_valid = 1; cand_row = 8'd13; cand_score = 6'd50;
    @(negedge clk);
    cand_valid = 0;
    check(merge_pending == 1, "R8 pending before clear", merge_pending, 1);
    clear = 1;
    @(negedge clk);
    clear = 0;
    model_empty();
    check(merge_pending == 0, "R8 pending dropped", merge_pending, 0);
    check_list("R8 empty");
    @(negedge clk);
    check_list("R8 held candidate lost");
    check(cand_ready == 1, "R8 ready again", cand_ready, 1);
  endtask

  task automatic offer1(input int r, input int s, input int er, input int es);
    @(negedge clk);
    v1 = 1; r1 = RW'(r); s1 = SW'(s);
    @(negedge clk);
    v1 = 0;
    @(negedge clk);
    check(rows1 == RW'(er), "R10 row", rows1, er);
    check(scores1 == SW'(es), "R10 score", scores1, es);
  endtask

  task automatic t_k1();
    check(rows1 == 8'hFF && scores1 == 0, "R10 empty", rows1, 255);
    offer1(4, 9, 4, 9);
    offer1(6, 12, 6, 12);
    offer1(2, 12, 2, 12);
    offer1(8, 3, 2, 12);
    offer1(1, 12, 1, 12);
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_evict();
    t_reject();
    t_clear_with_valid();
    t_clear_pending();
    t_k1();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule